// File: doc/BRIEF.md
# Real-Time-Clock Register Block with Masked Interrupts

This block is the register-side front end of a real-time clock. It keeps a 32-bit seconds counter that advances once for each cycle in which the one-pulse-per-second input is high. Software reads that count through the same 32-bit register bus that carries the alarm value, a control word, the calibration and sub-second readbacks, and two interrupt groups. The bus is a plain request/response bus. A request is taken in the idle state and answered exactly one cycle later, with a single-cycle ready pulse and the read data.

There are two interrupt groups. The clock group has two status bits: a seconds tick and an alarm match. The address-error group has one status bit, which is set whenever an access cannot be decoded. Every status bit is cleared by writing 1 to it. Each group has a mask that software can read but cannot write directly. A separate enable register clears mask bits and a separate disable register sets them. Each group drives a level interrupt that is high while any status bit is set and its mask bit is clear.

The bus controller has two states. In `BUS_IDLE` it waits for a request; when `req_valid` is seen it takes the transition *accept* to `BUS_RESP`. `BUS_RESP` drives `rsp_ready` for that one cycle and always takes the transition *complete* back to `BUS_IDLE`. Register side effects happen on the accept edge.

Top module: `rtc_regblock`

## Requirements
- R1: A request seen in the idle state is accepted. `rsp_ready` is then high for exactly the next cycle, with `rsp_rdata` valid. A request is never accepted in the cycle that `rsp_ready` is high. The effect of a write is visible to the next access.
- R2: The seconds count rises by one after every clock edge at which `tick_pps` is high, and holds otherwise. Byte offsets 0x00 and 0x04 both read the live count. Writes to either offset change nothing.
- R3: The clock interrupt status sits at offset 0x14, bits [1:0]. Bit 0 is set by each tick. Bit 1 is set during any cycle in which the seconds count equals the alarm value. Writing 1 to a bit clears it, and a set in the same cycle as a clear wins.
- R4: The clock mask at offset 0x18 resets to 2'b11 and ignores direct writes. Writing to offset 0x1C clears the mask bits where the data is 1. Writing to offset 0x20 sets them. Offsets 0x1C and 0x20 read as zero.
- R5: `irq_rtc` is high exactly while some clock status bit is 1 and its mask bit is 0. It follows a status or mask change in the same cycle that the register changes.
- R6: Address-error status is bit 0 at offset 0x24. It is set by any access that does not decode: a byte offset of 0x38 or above, an offset whose low two bits are not zero, or `req_strb` not equal to 4'hF. Such a read returns zero, such a write changes no register, and the response still comes after one cycle. Writing 1 clears the bit, and a set in the same cycle wins.
- R7: The error mask at offset 0x28 resets to 1 and is read-only. Offset 0x2C clears it and offset 0x30 sets it, both on a data bit 0 of 1. `irq_aerr` is high while the status is 1 and the mask is 0.
- R8: The control word at offset 0x34 resets to 32'h0100_0000. Bits in 32'h70FF_FFFE always read zero and ignore writes; the other bits are read/write.
- R9: The alarm word at offset 0x10 is a plain 32-bit read/write register that resets to zero.
- R10: Offset 0x08 reads the low 21 bits of parameter `CAL_VALUE`, zero-extended. Offset 0x0C reads `subsec_in` zero-extended. Writes to either offset are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_strb | input | 4 | Byte enables; only 4'hF decodes |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| tick_pps | input | 1 | One-cycle pulse per second |
| subsec_in | input | 16 | Sub-second count shown at offset 0x0C |
| irq_rtc | output | 1 | Clock interrupt level |
| irq_aerr | output | 1 | Address-error interrupt level |

## Verification
Register effects land on the accept edge. Read data and `rsp_ready` become visible after that edge, so every bus access is sampled on the falling edge that follows it. Interrupt levels depend on status and mask registers with no extra stage, so they are sampled on the same falling edge as the access or tick that changed them. A tick changes the count and status bit 0 one edge after the cycle in which it is driven, so reads of the count and status are issued only after the tick has dropped again. The same-cycle set-against-clear cases are produced by driving `tick_pps` in the exact cycle in which the clearing write is accepted, and by clearing bit 1 while the alarm still matches.

// File: rtl/rtc_regblock_pkg.sv
package rtc_regblock_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 14;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int ISTAT_W  = 2;
    localparam int ESTAT_W  = 1;
    localparam int CAL_W    = 21;
    localparam int FRAC_W   = 16;

    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0100_0000;
    localparam logic [DATA_W-1:0] CTRL_RSVD  = 32'h70FF_FFFE;

    // word index = byte offset / 4
    typedef enum logic [IDX_W-1:0] {
        RI_TIME_NOW = 4'd0,
        RI_TIME_RB  = 4'd1,
        RI_CAL      = 4'd2,
        RI_FRAC     = 4'd3,
        RI_ALARM    = 4'd4,
        RI_ISTAT    = 4'd5,
        RI_IMASK    = 4'd6,
        RI_IEN      = 4'd7,
        RI_IDIS     = 4'd8,
        RI_ESTAT    = 4'd9,
        RI_EMASK    = 4'd10,
        RI_EEN      = 4'd11,
        RI_EDIS     = 4'd12,
        RI_CTRL     = 4'd13
    } reg_idx_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_regblock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_strb,
    output logic              acc,
    output logic              map_ok,
    output reg_idx_e          idx,
    output logic              rsp_ready
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_REGS - 1);

    bus_state_e        state_q, state_d;
    logic [WORD_W-1:0] word;

    assign word = req_addr[ADDR_W-1:2];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_valid) state_d = BUS_RESP;  // accept
            BUS_RESP: state_d = BUS_IDLE;                  // complete
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        acc       = (state_q == BUS_IDLE) && req_valid;
        rsp_ready = (state_q == BUS_RESP);
        map_ok    = (req_addr[1:0] == 2'b00) && (word <= LAST_WORD) && (&req_strb);
        idx       = reg_idx_e'(word[IDX_W-1:0]);
    end

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] alarm,
    output logic [W-1:0] sec,
    output logic         match
);

    logic [W-1:0] sec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sec_q <= INIT;
        else if (tick) sec_q <= sec_q + W'(1);
    end

    assign sec   = sec_q;
    assign match = (sec_q == alarm);

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic         dis_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic         irq
);

    logic [W-1:0] stat_q, mask_q, stat_kept;

    // hardware set is applied after the software clear, so it wins
    assign stat_kept = clr_we ? (stat_q & ~wdata) : stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= stat_kept | hw_set;
            if (en_we)       mask_q <= mask_q & ~wdata;
            else if (dis_we) mask_q <= mask_q | wdata;
        end
    end

    assign stat = stat_q;
    assign mask = mask_q;
    assign irq  = |(stat_q & ~mask_q);

endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock
    import rtc_regblock_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter logic [DATA_W-1:0] CAL_VALUE    = '0,
    parameter logic [DATA_W-1:0] INIT_SECONDS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_strb,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    input  logic              tick_pps,
    input  logic [15:0]       subsec_in,
    output logic              irq_rtc,
    output logic              irq_aerr
);

    logic              bus_acc, bus_map_ok;
    reg_idx_e          bus_idx;
    logic              wr_hit;
    logic [DATA_W-1:0] sec_cnt, alarm_q, ctrl_q, rd_mux, rdata_q;
    logic              alarm_hit;
    logic [ISTAT_W-1:0] rtc_stat, rtc_mask;
    logic [ESTAT_W-1:0] aerr_stat, aerr_mask;

    rtc_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_strb  (req_strb),
        .acc       (bus_acc),
        .map_ok    (bus_map_ok),
        .idx       (bus_idx),
        .rsp_ready (rsp_ready)
    );

    assign wr_hit = bus_acc && req_write && bus_map_ok;

    rtc_sec_counter #(.W(DATA_W), .INIT(INIT_SECONDS)) u_sec (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_pps),
        .alarm (alarm_q),
        .sec   (sec_cnt),
        .match (alarm_hit)
    );

    rtc_irq_unit #(.W(ISTAT_W)) u_irq_rtc (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set ({alarm_hit, tick_pps}),
        .clr_we (wr_hit && bus_idx == RI_ISTAT),
        .en_we  (wr_hit && bus_idx == RI_IEN),
        .dis_we (wr_hit && bus_idx == RI_IDIS),
        .wdata  (req_wdata[ISTAT_W-1:0]),
        .stat   (rtc_stat),
        .mask   (rtc_mask),
        .irq    (irq_rtc)
    );

    rtc_irq_unit #(.W(ESTAT_W)) u_irq_aerr (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (bus_acc && !bus_map_ok),
        .clr_we (wr_hit && bus_idx == RI_ESTAT),
        .en_we  (wr_hit && bus_idx == RI_EEN),
        .dis_we (wr_hit && bus_idx == RI_EDIS),
        .wdata  (req_wdata[ESTAT_W-1:0]),
        .stat   (aerr_stat),
        .mask   (aerr_mask),
        .irq    (irq_aerr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
            ctrl_q  <= CTRL_RESET;
        end else if (wr_hit) begin
            if (bus_idx == RI_ALARM) alarm_q <= req_wdata;
            if (bus_idx == RI_CTRL)  ctrl_q  <= req_wdata & ~CTRL_RSVD;
        end
    end

    always_comb begin
        case (bus_idx)
            RI_TIME_NOW, RI_TIME_RB: rd_mux = sec_cnt;
            RI_CAL:   rd_mux = {{(DATA_W-CAL_W){1'b0}}, CAL_VALUE[CAL_W-1:0]};
            RI_FRAC:  rd_mux = {{(DATA_W-FRAC_W){1'b0}}, subsec_in};
            RI_ALARM: rd_mux = alarm_q;
            RI_ISTAT: rd_mux = {{(DATA_W-ISTAT_W){1'b0}}, rtc_stat};
            RI_IMASK: rd_mux = {{(DATA_W-ISTAT_W){1'b0}}, rtc_mask};
            RI_ESTAT: rd_mux = {{(DATA_W-ESTAT_W){1'b0}}, aerr_stat};
            RI_EMASK: rd_mux = {{(DATA_W-ESTAT_W){1'b0}}, aerr_mask};
            RI_CTRL:  rd_mux = ctrl_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (bus_acc) rdata_q <= (bus_map_ok && !req_write) ? rd_mux : '0;
    end

    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/rtc_regblock_chk.sv
module rtc_regblock_chk
    import rtc_regblock_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              rsp_ready,
    input logic [31:0]       rsp_rdata,
    input logic              tick_pps,
    input logic              bus_acc,
    input logic              bus_map_ok,
    input logic [DATA_W-1:0] sec_cnt,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [ISTAT_W-1:0] rtc_stat,
    input logic [ISTAT_W-1:0] rtc_mask,
    input logic [ESTAT_W-1:0] aerr_stat
);

    // R1
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R1
    ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready) |=> rsp_ready);

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pps |=> (sec_cnt == $past(sec_cnt) + 32'd1));

    // R2
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_pps |=> $stable(sec_cnt));

    // R3
    tick_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pps |=> rtc_stat[0]);

    // R4
    mask_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_acc && req_write) |=> $stable(rtc_mask));

    // R6
    aerr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_acc && !bus_map_ok) |=> aerr_stat[0]);

    // R6
    aerr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_acc && !bus_map_ok) |=> (rsp_rdata == 32'd0));

    // R8
    ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & CTRL_RSVD) == 32'd0);

endmodule

bind rtc_regblock rtc_regblock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .tick_pps   (tick_pps),
    .bus_acc    (bus_acc),
    .bus_map_ok (bus_map_ok),
    .sec_cnt    (sec_cnt),
    .ctrl_q     (ctrl_q),
    .rtc_stat   (rtc_stat),
    .rtc_mask   (rtc_mask),
    .aerr_stat  (aerr_stat)
);

// File: tb/rtc_regblock_tb.sv
module rtc_regblock_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 20000;
    localparam int NV         = 40;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  strb;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h14, 4'hF, 32'h0,        1'b1, 32'h2,         4'd3},  // R3 alarm 0 matches count 0
        '{1'b1, 8'h14, 4'hF, 32'h2,        1'b0, 32'h0,         4'd3},
        '{1'b0, 8'h14, 4'hF, 32'h0,        1'b1, 32'h2,         4'd3},  // R3 set wins over clear
        '{1'b0, 8'h34, 4'hF, 32'h0,        1'b1, 32'h0100_0000, 4'd8},  // R8
        '{1'b1, 8'h34, 4'hF, 32'hFFFF_FFFF,1'b0, 32'h0,         4'd8},
        '{1'b0, 8'h34, 4'hF, 32'h0,        1'b1, 32'h8F00_0001, 4'd8},  // R8
        '{1'b1, 8'h10, 4'hF, 32'h1234_5678,1'b0, 32'h0,         4'd9},
        '{1'b0, 8'h10, 4'hF, 32'h0,        1'b1, 32'h1234_5678, 4'd9},  // R9
        '{1'b1, 8'h14, 4'hF, 32'h3,        1'b0, 32'h0,         4'd3},
        '{1'b0, 8'h14, 4'hF, 32'h0,        1'b1, 32'h0,         4'd3},  // R3 w1c
        '{1'b0, 8'h18, 4'hF, 32'h0,        1'b1, 32'h3,         4'd4},  // R4
        '{1'b1, 8'h1C, 4'hF, 32'h1,        1'b0, 32'h0,         4'd4},
        '{1'b0, 8'h18, 4'hF, 32'h0,        1'b1, 32'h2,         4'd4},  // R4
        '{1'b0, 8'h1C, 4'hF, 32'h0,        1'b1, 32'h0,         4'd4},  // R4
        '{1'b1, 8'h20, 4'hF, 32'h3,        1'b0, 32'h0,         4'd4},
        '{1'b0, 8'h18, 4'hF, 32'h0,        1'b1, 32'h3,         4'd4},  // R4
        '{1'b0, 8'h20, 4'hF, 32'h0,        1'b1, 32'h0,         4'd4},  // R4
        '{1'b1, 8'h18, 4'hF, 32'h0,        1'b0, 32'h0,         4'd4},
        '{1'b0, 8'h18, 4'hF, 32'h0,        1'b1, 32'h3,         4'd4},  // R4 direct write ignored
        '{1'b0, 8'h28, 4'hF, 32'h0,        1'b1, 32'h1,         4'd7},  // R7
        '{1'b0, 8'h08, 4'hF, 32'h0,        1'b1, 32'h0000_1234, 4'd10}, // R10
        '{1'b0, 8'h0C, 4'hF, 32'h0,        1'b1, 32'h0000_BEEF, 4'd10}, // R10
        '{1'b1, 8'h00, 4'hF, 32'hFFFF,     1'b0, 32'h0,         4'd2},
        '{1'b0, 8'h00, 4'hF, 32'h0,        1'b1, 32'h0,         4'd2},  // R2 write ignored
        '{1'b0, 8'h04, 4'hF, 32'h0,        1'b1, 32'h0,         4'd2},  // R2
        '{1'b0, 8'h24, 4'hF, 32'h0,        1'b1, 32'h0,         4'd6},  // R6
        '{1'b0, 8'h38, 4'hF, 32'h0,        1'b1, 32'h0,         4'd6},  // R6 unmapped reads zero
        '{1'b0, 8'h24, 4'hF, 32'h0,        1'b1, 32'h1,         4'd6},  // R6
        '{1'b1, 8'h24, 4'hF, 32'h1,        1'b0, 32'h0,         4'd6},
        '{1'b0, 8'h24, 4'hF, 32'h0,        1'b1, 32'h0,         4'd6},  // R6 w1c
        '{1'b1, 8'h36, 4'hF, 32'h0,        1'b0, 32'h0,         4'd6},
        '{1'b0, 8'h24, 4'hF, 32'h0,        1'b1, 32'h1,         4'd6},  // R6 misaligned
        '{1'b1, 8'h24, 4'hF, 32'h1,        1'b0, 32'h0,         4'd6},
        '{1'b1, 8'h34, 4'h1, 32'h0,        1'b0, 32'h0,         4'd6},
        '{1'b0, 8'h34, 4'hF, 32'h0,        1'b1, 32'h8F00_0001, 4'd6},  // R6 partial write no effect
        '{1'b0, 8'h24, 4'hF, 32'h0,        1'b1, 32'h1,         4'd6},  // R6 partial strobe
        '{1'b1, 8'h24, 4'hF, 32'h1,        1'b0, 32'h0,         4'd6},
        '{1'b0, 8'hFC, 4'hF, 32'h0,        1'b1, 32'h0,         4'd6},  // R6 top offset
        '{1'b1, 8'h24, 4'hF, 32'h1,        1'b0, 32'h0,         4'd6},
        '{1'b0, 8'h24, 4'hF, 32'h0,        1'b1, 32'h0,         4'd6}   // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_strb = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        tick_pps = 1'b0;
    logic [15:0] subsec_in = 16'hBEEF;
    logic        rsp_ready, irq_rtc, irq_aerr;
    logic [31:0] rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regblock #(.ADDR_W(8), .CAL_VALUE(32'hFFE0_1234)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_strb  (req_strb),
        .req_wdata (req_wdata),
        .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata),
        .tick_pps  (tick_pps),
        .subsec_in (subsec_in),
        .irq_rtc   (irq_rtc),
        .irq_aerr  (irq_aerr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, accept at the next rising edge, sample the response after it
    task automatic access(input logic wr, input logic [7:0] addr, input logic [3:0] strb,
                          input logic [31:0] wdata, input logic with_tick,
                          output logic [31:0] rdata, output logic rdy);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_strb  = strb;
        req_wdata = wdata;
        tick_pps  = with_tick;
        @(posedge clk);
        @(negedge clk);
        rdata     = rsp_rdata;
        rdy       = rsp_ready;
        req_valid = 1'b0;
        tick_pps  = 1'b0;
        @(posedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] addr, input logic [31:0] wdata);
        logic [31:0] d;
        logic r;
        access(1'b1, addr, 4'hF, wdata, 1'b0, d, r);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] addr, input logic [31:0] exp);
        logic [31:0] d;
        logic r;
        access(1'b0, addr, 4'hF, 32'h0, 1'b0, d, r);
        check(tag, d, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_pps = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_pps = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic r;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset ready", {31'b0, rsp_ready}, 32'd0);
        check("R5 reset irq_rtc", {31'b0, irq_rtc}, 32'd0);
        check("R7 reset irq_aerr", {31'b0, irq_aerr}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].strb, VECS[i].wdata, 1'b0, d, r);
            if (VECS[i].chk)
                check($sformatf("R%0d vec%0d", VECS[i].req, i), d, VECS[i].exp);
        end

        // R1 handshake timing
        access(1'b0, 8'h10, 4'hF, 32'h0, 1'b0, d, r);
        check("R1 ready after accept", {31'b0, r}, 32'd1);
        @(negedge clk);
        check("R1 ready one cycle", {31'b0, rsp_ready}, 32'd0);

        // R2/R3/R5 ticks and clock interrupt
        wr_reg(8'h10, 32'd3);
        pulse_tick();
        check("R5 masked irq", {31'b0, irq_rtc}, 32'd0);
        rd_chk("R2 time now", 8'h00, 32'd1);
        rd_chk("R2 time readback", 8'h04, 32'd1);
        rd_chk("R3 tick bit", 8'h14, 32'd1);
        wr_reg(8'h1C, 32'd1);
        check("R5 enabled irq", {31'b0, irq_rtc}, 32'd1);
        wr_reg(8'h14, 32'd1);
        check("R5 cleared irq", {31'b0, irq_rtc}, 32'd0);
        pulse_tick();
        check("R5 irq on tick", {31'b0, irq_rtc}, 32'd1);
        pulse_tick();
        rd_chk("R3 alarm bit", 8'h14, 32'd3);
        access(1'b1, 8'h14, 4'hF, 32'd1, 1'b1, d, r);
        rd_chk("R3 tick beats clear", 8'h14, 32'd3);
        rd_chk("R2 count after four", 8'h00, 32'd4);
        wr_reg(8'h14, 32'd3);
        rd_chk("R3 cleared both", 8'h14, 32'd0);
        check("R5 irq low", {31'b0, irq_rtc}, 32'd0);

        // R7 address-error interrupt
        wr_reg(8'h2C, 32'd1);
        rd_chk("R7 mask cleared", 8'h28, 32'd0);
        check("R7 no status", {31'b0, irq_aerr}, 32'd0);
        rd_chk("R6 bad read zero", 8'h40, 32'd0);
        check("R7 irq set", {31'b0, irq_aerr}, 32'd1);
        wr_reg(8'h30, 32'd1);
        check("R7 irq masked", {31'b0, irq_aerr}, 32'd0);
        rd_chk("R7 mask set", 8'h28, 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule